// File: doc/BRIEF.md
# Parallel Display Bus Master

This block drives a 16-bit, 8080-style parallel display bus from a simple internal request port. Each request is one bus access: a write with the register-select line low (an index write), a write with it high (a data write), or a read. A panel register is programmed by issuing an index write followed by a data write. The block drives chip select, register select, a write strobe and a read strobe, all active low except register select. It presents outgoing data on a separate data-out bus qualified by an output enable, and takes returning data from a separate data-in bus.

Three timing counts shape every access. A setup count sets the cycles between chip select falling and the strobe. A strobe count sets the write strobe width. A read-latency count sets how long the read strobe stays low; the data-in bus is sampled in the last of those cycles. A count of zero on any timing input selects that count's parameter default (setup 2, strobe 3, read latency 10).

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_rs`, `req_read` and `req_wdata` steady until that edge. `req_ready` stays low from acceptance until the block has returned to idle. Completion is reported by a one-cycle `ack` pulse, which cannot be stalled.

Top module: `lcd_bus_master`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are high, `lcd_oe` and `ack` are low, `lcd_dout` is zero and `req_ready` is high.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance through the `ack` cycle, so a request held during an access or during the `ack` cycle waits for the next idle cycle.
- R3: `lcd_cs_n` is low from the cycle after acceptance through the last strobe cycle. It is high in the `ack` cycle, so it is high for at least one cycle between two accesses.
- R4: `lcd_rs` equals the accepted `req_rs` (0 = index, 1 = data) for the whole time chip select is low.
- R5: After acceptance, both strobes stay high for S cycles with chip select low. S is `cfg_setup`, or 2 when `cfg_setup` is 0.
- R6: For a write (`req_read` = 0), `lcd_wr_n` is low for exactly W cycles right after the setup phase. W is `cfg_strobe`, or 3 when it is 0. `lcd_rd_n` stays high throughout.
- R7: For a read (`req_read` = 1), `lcd_rd_n` is low for exactly L cycles right after the setup phase. L is `cfg_rdlat`, or 10 when it is 0. `lcd_din` is sampled in the last of those L cycles and `lcd_wr_n` stays high.
- R8: During a write access (setup and strobe phases), `lcd_oe` is high and `lcd_dout` equals the accepted `req_wdata`. At all other times, including the whole of a read, `lcd_oe` is low and `lcd_dout` is zero.
- R9: `ack` is high for exactly one cycle, the cycle after the last strobe cycle. `rsp_rdata` then holds the sampled read data, and keeps its value until the next read completes.
- R10: The timing counts are taken at acceptance. Changing `cfg_setup`, `cfg_strobe` or `cfg_rdlat` during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_rs | input | 1 | Register-select level for the access (0 index, 1 data) |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read data, valid with `ack` |
| cfg_setup | input | 8 | Setup cycles (0 = default) |
| cfg_strobe | input | 8 | Write strobe cycles (0 = default) |
| cfg_rdlat | input | 8 | Read strobe/latency cycles (0 = default) |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dout | output | 16 | Data driven toward the pads |
| lcd_oe | output | 1 | Output enable for `lcd_dout` |
| lcd_din | input | 16 | Data returned from the pads |

## Verification
Two events can fall in the same cycle: the `ack` of a finishing access and a new request that the requester already holds valid. The bench raises the next request during the `ack` cycle of the previous one. It checks that `req_ready` is still low there and that chip select stays high before the new setup phase starts. A change of timing inputs can also coincide with an access in progress. The bench rewrites the counts in the first setup cycle and judges that access against the counts captured when it was accepted.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_GAP    = 2'd3
  } phase_t;

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (len != '0));

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/lcd_bus_sequencer.sv
module lcd_bus_sequencer
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int SETUP_DEF  = 2,
  parameter int STROBE_DEF = 3,
  parameter int RDLAT_DEF  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_rs,
  input  logic              req_read,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_rdlat,
  input  logic              timer_last,
  output phase_t            phase,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_len,
  output logic              acc_rs,
  output logic              acc_rd,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              capture
);

  localparam logic [CNT_W-1:0] SETUP_D  = CNT_W'(SETUP_DEF);
  localparam logic [CNT_W-1:0] STROBE_D = CNT_W'(STROBE_DEF);
  localparam logic [CNT_W-1:0] RDLAT_D  = CNT_W'(RDLAT_DEF);

  function automatic logic [CNT_W-1:0] pick(input logic [CNT_W-1:0] v,
                                            input logic [CNT_W-1:0] d);
    return (v == '0) ? d : v;
  endfunction

  phase_t           state, state_nx;
  logic [CNT_W-1:0] lat_strobe;
  logic [CNT_W-1:0] lat_rdlat;
  logic             accept;
  logic             setup_done;

  assign accept     = req_valid && (state == PH_IDLE);
  assign setup_done = (state == PH_SETUP) && timer_last;
  assign timer_load = accept || setup_done;
  assign timer_len  = accept ? pick(cfg_setup, SETUP_D)
                             : (acc_rd ? lat_rdlat : lat_strobe);
  assign capture    = (state == PH_STROBE) && timer_last && acc_rd;
  assign phase      = state;

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:   if (accept)     state_nx = PH_SETUP;
      PH_SETUP:  if (timer_last) state_nx = PH_STROBE;
      PH_STROBE: if (timer_last) state_nx = PH_GAP;
      PH_GAP:                    state_nx = PH_IDLE;
      default:                   state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      acc_rs     <= 1'b0;
      acc_rd     <= 1'b0;
      acc_wdata  <= '0;
      lat_strobe <= STROBE_D;
      lat_rdlat  <= RDLAT_D;
    end else begin
      state <= state_nx;
      if (accept) begin
        acc_rs     <= req_rs;
        acc_rd     <= req_read;
        acc_wdata  <= req_wdata;
        lat_strobe <= pick(cfg_strobe, STROBE_D);
        lat_rdlat  <= pick(cfg_rdlat, RDLAT_D);
      end
    end
  end

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_IDLE) |=> ($stable(lat_strobe) && $stable(lat_rdlat)));

  assert_attrs_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_IDLE) |=> ($stable(acc_rs) && $stable(acc_rd) && $stable(acc_wdata)));

  assert_gap_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_GAP) |=> (state == PH_IDLE));

endmodule

// File: rtl/lcd_read_capture.sv
module lcd_read_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= din;
  end

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata));

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int SETUP_DEF  = 2,
  parameter int STROBE_DEF = 3,
  parameter int RDLAT_DEF  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rs,
  input  logic              req_read,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_strobe,
  input  logic [CNT_W-1:0]  cfg_rdlat,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic [DATA_W-1:0] lcd_dout,
  output logic              lcd_oe,
  input  logic [DATA_W-1:0] lcd_din
);

  phase_t            phase;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_len;
  logic              timer_last;
  logic              acc_rs;
  logic              acc_rd;
  logic [DATA_W-1:0] acc_wdata;
  logic              capture;
  logic              in_access;

  lcd_bus_sequencer #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SETUP_DEF(SETUP_DEF),
    .STROBE_DEF(STROBE_DEF), .RDLAT_DEF(RDLAT_DEF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs),
    .req_read(req_read), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_rdlat(cfg_rdlat), .timer_last(timer_last),
    .phase(phase), .timer_load(timer_load), .timer_len(timer_len),
    .acc_rs(acc_rs), .acc_rd(acc_rd), .acc_wdata(acc_wdata), .capture(capture)
  );

  lcd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .len(timer_len), .last(timer_last)
  );

  lcd_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .din(lcd_din), .rdata(rsp_rdata)
  );

  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign req_ready = (phase == PH_IDLE);
  assign ack       = (phase == PH_GAP);
  assign lcd_cs_n  = !in_access;
  assign lcd_rs    = acc_rs;
  assign lcd_wr_n  = !((phase == PH_STROBE) && !acc_rd);
  assign lcd_rd_n  = !((phase == PH_STROBE) && acc_rd);
  assign lcd_oe    = in_access && !acc_rd;
  assign lcd_dout  = lcd_oe ? acc_wdata : '0;

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n);

  assert_oe_write_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_oe |-> (lcd_rd_n && !lcd_cs_n));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_cs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (lcd_cs_n && !req_ready));

  assert_rs_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_rs));

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/tb_lcd_bus_master.sv
module tb_lcd_bus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_rs = 1'b0;
  logic        req_read = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        ack;
  logic [15:0] rsp_rdata;
  logic [7:0]  cfg_setup = '0;
  logic [7:0]  cfg_strobe = '0;
  logic [7:0]  cfg_rdlat = '0;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_oe;
  logic [15:0] lcd_dout;
  logic [15:0] lcd_din = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_read = '0;

  always #2.5 clk = ~clk;

  lcd_bus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_read(req_read), .req_wdata(req_wdata), .ack(ack),
    .rsp_rdata(rsp_rdata), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_rdlat(cfg_rdlat), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs),
    .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout),
    .lcd_oe(lcd_oe), .lcd_din(lcd_din)
  );

  function automatic int eff(input int v, input int d);
    return (v == 0) ? d : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(lcd_cs_n == 1'b1, req, lcd_cs_n, 1);
    chk(lcd_wr_n == 1'b1 && lcd_rd_n == 1'b1, req, {lcd_wr_n, lcd_rd_n}, 3);
    chk(lcd_oe == 1'b0 && lcd_dout == 16'h0, req, {lcd_oe, lcd_dout}, 0);
    chk(ack == 1'b0, req, ack, 0);
    chk(req_ready == 1'b1, req, req_ready, 1);
  endtask

  // Called at a negedge. Performs one access and returns at the negedge of its ack cycle.
  task automatic access(input bit rs, input bit rd, input logic [15:0] wd,
                        input logic [15:0] rv, input bit mid_cfg);
    int s, w;
    req_valid = 1'b1; req_rs = rs; req_read = rd; req_wdata = wd;
    if (!req_ready) begin
      // R2: request raised in the ack cycle of the previous access must wait
      chk(lcd_cs_n == 1'b1, "R3", lcd_cs_n, 1);
      @(negedge clk);
      chk(req_ready == 1'b1 && lcd_cs_n == 1'b1, "R2", {req_ready, lcd_cs_n}, 3);
    end
    s = eff(int'(cfg_setup), 2);
    w = rd ? eff(int'(cfg_rdlat), 10) : eff(int'(cfg_strobe), 3);
    @(posedge clk);
    for (int n = 1; n <= s + w + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = 1'b0;
        req_wdata = ~wd;
        req_rs = ~rs;
        if (mid_cfg) begin
          cfg_setup  = 8'($urandom_range(0, 6));
          cfg_strobe = 8'($urandom_range(0, 6));
          cfg_rdlat  = 8'($urandom_range(0, 12));
        end
      end
      if (n <= s + w) begin
        chk(lcd_cs_n == 1'b0, "R3", lcd_cs_n, 0);
        chk(lcd_rs == rs, "R4", lcd_rs, rs);
        chk(req_ready == 1'b0 && ack == 1'b0, "R2", {req_ready, ack}, 0);
        chk(lcd_oe == !rd, "R8", lcd_oe, !rd);
        chk(lcd_dout == (rd ? 16'h0 : wd), "R8", lcd_dout, rd ? 0 : wd);
      end
      if (n <= s) begin
        chk(lcd_wr_n == 1'b1 && lcd_rd_n == 1'b1, "R5", {lcd_wr_n, lcd_rd_n}, 3);
      end else if (n <= s + w) begin
        if (rd) chk(lcd_rd_n == 1'b0 && lcd_wr_n == 1'b1, "R7 R10", {lcd_wr_n, lcd_rd_n}, 2);
        else    chk(lcd_wr_n == 1'b0 && lcd_rd_n == 1'b1, "R6 R10", {lcd_wr_n, lcd_rd_n}, 1);
        lcd_din = (n == s + w) ? rv : ~rv;
      end else begin
        chk(ack == 1'b1, "R9", ack, 1);
        chk(lcd_cs_n == 1'b1 && lcd_wr_n && lcd_rd_n, "R3", {lcd_cs_n, lcd_wr_n, lcd_rd_n}, 7);
        chk(lcd_oe == 1'b0, "R8", lcd_oe, 0);
        chk(req_ready == 1'b0, "R2", req_ready, 0);
        if (rd) last_read = rv;
        chk(rsp_rdata == last_read, rd ? "R7" : "R9", rsp_rdata, last_read);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1A2B);
    repeat (3) @(negedge clk);
    idle_outputs("R1");
    chk(rsp_rdata == 16'h0, "R1", rsp_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_outputs("R1");

    // Directed: defaults, a register write pair and a read
    access(1'b0, 1'b0, 16'h0022, 16'h0, 1'b0);
    access(1'b1, 1'b0, 16'h1690, 16'h0, 1'b0);
    access(1'b1, 1'b1, 16'h0, 16'h9325, 1'b0);
    @(negedge clk);
    idle_outputs("R2");
    // Minimal counts
    cfg_setup = 8'd1; cfg_strobe = 8'd1; cfg_rdlat = 8'd1;
    access(1'b1, 1'b1, 16'h0, 16'hBEEF, 1'b0);
    access(1'b0, 1'b0, 16'hA5A5, 16'h0, 1'b0);
    // Long strobes
    cfg_setup = 8'd9; cfg_strobe = 8'd40; cfg_rdlat = 8'd60;
    access(1'b1, 1'b0, 16'h5A5A, 16'h0, 1'b0);
    access(1'b0, 1'b1, 16'h0, 16'h1234, 1'b0);
    // Counts rewritten during an access (R10)
    cfg_setup = 8'd3; cfg_strobe = 8'd2; cfg_rdlat = 8'd4;
    access(1'b1, 1'b1, 16'h0, 16'h4321, 1'b1);
    access(1'b1, 1'b0, 16'h7777, 16'h0, 1'b1);

    // Random mix, often back-to-back from the ack cycle
    for (int i = 0; i < 300; i++) begin
      bit rs, rd, gap;
      rs = 1'($urandom);
      rd = 1'($urandom);
      gap = ($urandom_range(0, 3) == 0);
      if (gap) begin
        @(negedge clk);
        idle_outputs("R2");
      end
      if (!$urandom_range(0, 4)) begin
        cfg_setup  = 8'($urandom_range(0, 6));
        cfg_strobe = 8'($urandom_range(0, 6));
        cfg_rdlat  = 8'($urandom_range(0, 12));
      end
      access(rs, rd, 16'($urandom), 16'($urandom), ($urandom_range(0, 2) == 0));
    end
    @(negedge clk);
    idle_outputs("R2");
    chk(rsp_rdata == last_read, "R9", rsp_rdata, last_read);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule